// File: doc/BRIEF.md
# Relocatable Configuration Window Decoder

This block decodes the memory addresses of a 4 KB configuration register region. The region always answers at one fixed page near the top of the 4 GB space. Software may also open a second copy of it, an alias, on any 4 KB page below the 1 GB line. For each memory address on its input, the block reports whether the address falls in the fixed page, in the alias page, or in either one. It also gives the 12-bit offset into the region.

The alias is set through a 32-bit base register at a fixed I/O port. A key guards this register, so one stray write cannot move or enable the alias. Software first writes the arming value. The next write to the same port then loads the new contents. Any other I/O access in between cancels the arming. Reading the port returns the register and leaves the key state unchanged. All outputs are registered and appear one clock after their inputs.

Top module: `cwin_decoder`

## Requirements
- R1: After a synchronous reset, the base register reads 0, the key is not armed, and all hit outputs, the offset and the read data are 0.
- R2: A memory address with bits 31:12 equal to 0xFFFEF sets hit_fixed one cycle later, whatever the register holds.
- R3: While the key is not armed, a write to port 0xFFFC leaves the register unchanged.
- R4: A write of exactly 0x80000000 to port 0xFFFC arms the key. The next I/O write to 0xFFFC loads the register and disarms the key.
- R5: Any I/O write or read to a port other than 0xFFFC disarms the key. So does a write to 0xFFFC of a value other than 0x80000000 while the key is not armed.
- R6: Register layout: bit 31 is the alias enable, bits 29:12 are the alias page, and every other bit is stored and read as 0.
- R7: hit_alias is set one cycle later when the enable bit is 1, address bits 31:30 are 0, and address bits 29:12 equal the stored alias page.
- R8: hit_any is the OR of hit_fixed and hit_alias. offset carries address bits 11:0 when hit_any is 1 and is 0 otherwise.
- R9: An I/O read of port 0xFFFC returns the register one cycle later and does not change the key state. A read of any other port returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_wr | input | 1 | I/O write strobe, one cycle per access |
| io_rd | input | 1 | I/O read strobe, one cycle per access |
| io_port | input | 16 | I/O port address |
| io_wdata | input | 32 | I/O write data |
| io_rdata | output | 32 | I/O read data, valid the cycle after io_rd |
| mem_addr | input | 32 | Memory address to decode |
| hit_fixed | output | 1 | Address is in the fixed page |
| hit_alias | output | 1 | Address is in the alias page |
| hit_any | output | 1 | Address is in either page |
| offset | output | 12 | Offset into the region |

## Verification
The hardest state to reach from the ports is an armed key that meets a disturbing access: a read of the base port, a read or write of a foreign port, or a repeated key value. Each of these must be followed by the loading write before its effect shows. Directed sequences cover each of these interruptions. A seeded random mix of key writes, plain writes, foreign accesses and reads then reaches the armed state again and again, with varied interruptions. Memory probes are biased toward the fixed page, the current alias page and pages just outside the 1 GB line, so alias hits and near misses both occur often.

// File: rtl/cwin_pkg.sv
package cwin_pkg;
  localparam int unsigned ADDR_W     = 32;
  localparam int unsigned IO_W       = 16;
  localparam int unsigned PAGE_W     = 12;
  localparam int unsigned LIMIT_W    = 30;
  localparam logic [15:0] CFG_PORT   = 16'hFFFC;
  localparam logic [31:0] FIXED_BASE = 32'hFFFE_F000;
  localparam logic [31:0] ARM_KEY    = 32'h8000_0000;
  localparam int unsigned NUM_WIN    = 2;
  localparam int unsigned WIN_FIXED  = 0;
  localparam int unsigned WIN_ALIAS  = 1;
endpackage

// File: rtl/cwin_cfg_reg.sv
module cwin_cfg_reg #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned IO_W    = 16,
  parameter int unsigned PAGE_W  = 12,
  parameter int unsigned LIMIT_W = 30,
  parameter logic [IO_W-1:0]   PORT = 16'hFFFC,
  parameter logic [ADDR_W-1:0] KEY  = 32'h8000_0000
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     io_wr,
  input  logic                     io_rd,
  input  logic [IO_W-1:0]          io_port,
  input  logic [ADDR_W-1:0]        io_wdata,
  output logic [ADDR_W-1:0]        io_rdata,
  output logic                     alias_en,
  output logic [ADDR_W-PAGE_W-1:0] alias_page
);
  localparam int unsigned PN_W = ADDR_W - PAGE_W;
  localparam int unsigned AP_W = LIMIT_W - PAGE_W;
  localparam logic [ADDR_W-1:0] ONES = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] MASK =
    ((ONES << PAGE_W) & ~(ONES << LIMIT_W)) | (ADDR_W'(1) << (ADDR_W-1));

  logic [ADDR_W-1:0] cfg_q;
  logic              armed_q;
  logic              port_hit;
  logic              key_match;

  assign port_hit  = (io_port == PORT);
  assign key_match = (io_wdata == KEY);

  // keyed register and arming state; a write wins over a read in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      armed_q <= 1'b0;
    end else if (io_wr) begin
      if (port_hit && armed_q) begin
        cfg_q   <= io_wdata & MASK;
        armed_q <= 1'b0;
      end else if (port_hit) begin
        armed_q <= key_match;
      end else begin
        armed_q <= 1'b0;
      end
    end else if (io_rd && !port_hit) begin
      armed_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      io_rdata <= '0;
    else if (io_rd && port_hit)
      io_rdata <= cfg_q;
    else
      io_rdata <= '0;
  end

  assign alias_en   = cfg_q[ADDR_W-1];
  assign alias_page = PN_W'(cfg_q[LIMIT_W-1:PAGE_W]);

  p_no_load_unarmed_r3: assert property (@(posedge clk) disable iff (rst)
    !(io_wr && port_hit && armed_q) |=> $stable(cfg_q));

  p_arm_only_by_key_r4: assert property (@(posedge clk) disable iff (rst)
    (!armed_q && !(io_wr && port_hit && key_match)) |=> !armed_q);

  p_load_disarms_r4: assert property (@(posedge clk) disable iff (rst)
    (io_wr && port_hit && armed_q) |=> !armed_q);

  p_foreign_disarms_r5: assert property (@(posedge clk) disable iff (rst)
    ((io_wr || io_rd) && !port_hit) |=> !armed_q);

  p_reserved_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (cfg_q & ~MASK) == '0);

  p_read_keeps_key_r9: assert property (@(posedge clk) disable iff (rst)
    (io_rd && !io_wr && port_hit) |=> (armed_q == $past(armed_q)));

  logic [AP_W-1:0] unused_chk;
  assign unused_chk = '0;
endmodule

// File: rtl/cwin_match.sv
module cwin_match #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PAGE_W = 12
) (
  input  logic [ADDR_W-1:0]        addr,
  input  logic [ADDR_W-PAGE_W-1:0] page,
  input  logic                     en,
  output logic                     hit,
  output logic [PAGE_W-1:0]        offset
);
  always_comb begin
    hit    = en && (addr[ADDR_W-1:PAGE_W] == page);
    offset = addr[PAGE_W-1:0];
  end
endmodule

// File: rtl/cwin_decoder.sv
module cwin_decoder
  import cwin_pkg::*;
#(
  parameter int unsigned P_ADDR_W  = ADDR_W,
  parameter int unsigned P_IO_W    = IO_W,
  parameter int unsigned P_PAGE_W  = PAGE_W,
  parameter int unsigned P_LIMIT_W = LIMIT_W,
  parameter logic [P_IO_W-1:0]   P_PORT  = CFG_PORT,
  parameter logic [P_ADDR_W-1:0] P_FIXED = FIXED_BASE,
  parameter logic [P_ADDR_W-1:0] P_KEY   = ARM_KEY
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  io_wr,
  input  logic                  io_rd,
  input  logic [P_IO_W-1:0]     io_port,
  input  logic [P_ADDR_W-1:0]   io_wdata,
  output logic [P_ADDR_W-1:0]   io_rdata,
  input  logic [P_ADDR_W-1:0]   mem_addr,
  output logic                  hit_fixed,
  output logic                  hit_alias,
  output logic                  hit_any,
  output logic [P_PAGE_W-1:0]   offset
);
  localparam int unsigned PN_W = P_ADDR_W - P_PAGE_W;

  logic            alias_en;
  logic [PN_W-1:0] alias_page;

  logic [PN_W-1:0]     win_page [NUM_WIN];
  logic                win_en   [NUM_WIN];
  logic                win_hit  [NUM_WIN];
  logic [P_PAGE_W-1:0] win_off  [NUM_WIN];

  cwin_cfg_reg #(
    .ADDR_W(P_ADDR_W), .IO_W(P_IO_W), .PAGE_W(P_PAGE_W),
    .LIMIT_W(P_LIMIT_W), .PORT(P_PORT), .KEY(P_KEY)
  ) u_cfg (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd),
    .io_port(io_port), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .alias_en(alias_en), .alias_page(alias_page)
  );

  assign win_page[WIN_FIXED] = P_FIXED[P_ADDR_W-1:P_PAGE_W];
  assign win_en[WIN_FIXED]   = 1'b1;
  assign win_page[WIN_ALIAS] = alias_page;
  assign win_en[WIN_ALIAS]   = alias_en;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    cwin_match #(.ADDR_W(P_ADDR_W), .PAGE_W(P_PAGE_W)) u_match (
      .addr(mem_addr), .page(win_page[w]), .en(win_en[w]),
      .hit(win_hit[w]), .offset(win_off[w])
    );
  end

  logic any_c;
  assign any_c = win_hit[WIN_FIXED] || win_hit[WIN_ALIAS];

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_fixed <= 1'b0;
      hit_alias <= 1'b0;
      hit_any   <= 1'b0;
      offset    <= '0;
    end else begin
      hit_fixed <= win_hit[WIN_FIXED];
      hit_alias <= win_hit[WIN_ALIAS];
      hit_any   <= any_c;
      offset    <= win_hit[WIN_FIXED] ? win_off[WIN_FIXED] :
                   win_hit[WIN_ALIAS] ? win_off[WIN_ALIAS] : '0;
    end
  end

  p_fixed_page_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(mem_addr[P_ADDR_W-1:P_PAGE_W]) == P_FIXED[P_ADDR_W-1:P_PAGE_W]) |-> hit_fixed);

  p_alias_low_r7: assert property (@(posedge clk) disable iff (rst)
    hit_alias |-> ($past(mem_addr[P_ADDR_W-1:P_LIMIT_W]) == '0));

  p_offset_r8: assert property (@(posedge clk) disable iff (rst)
    hit_any |-> (offset == $past(mem_addr[P_PAGE_W-1:0])));

  p_miss_zero_r8: assert property (@(posedge clk) disable iff (rst)
    !hit_any |-> (offset == '0 && !hit_fixed && !hit_alias));
endmodule

// File: tb/cwin_decoder_bench.sv
module cwin_decoder_bench;
  localparam logic [15:0] PORT = 16'hFFFC;
  localparam logic [31:0] KEY  = 32'h8000_0000;
  localparam logic [31:0] MASK = 32'hBFFF_F000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [15:0] io_port = '0;
  logic [31:0] io_wdata = '0, io_rdata, mem_addr = '0;
  logic        hit_fixed, hit_alias, hit_any;
  logic [11:0] offset;

  int checks = 0, errors = 0;
  logic [31:0] m_reg = '0;
  logic        m_armed = 1'b0;

  always #4 clk = ~clk;

  cwin_decoder u_cwin_decoder (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_port(io_port),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .mem_addr(mem_addr),
    .hit_fixed(hit_fixed), .hit_alias(hit_alias), .hit_any(hit_any), .offset(offset)
  );

  function automatic logic f_fixed(logic [31:0] a);
    return a[31:12] == 20'hFFFEF;
  endfunction

  function automatic logic f_alias(logic [31:0] a, logic [31:0] r);
    return r[31] && a[31:30] == 2'b00 && a[29:12] == r[29:12];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic io_write(logic [15:0] p, logic [31:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_port = p; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0;
    if (p == PORT) begin
      if (m_armed) begin m_reg = d & MASK; m_armed = 1'b0; end
      else m_armed = (d == KEY);
    end else m_armed = 1'b0;
  endtask

  task automatic io_read(logic [15:0] p, string req);
    @(negedge clk);
    io_rd = 1'b1; io_port = p;
    @(posedge clk); #1;
    check(req, io_rdata, (p == PORT) ? m_reg : 32'h0);
    @(negedge clk);
    io_rd = 1'b0;
    if (p != PORT) m_armed = 1'b0;
  endtask

  task automatic probe(logic [31:0] a, string req);
    logic ef, ea;
    ef = f_fixed(a); ea = f_alias(a, m_reg);
    @(negedge clk);
    mem_addr = a;
    @(posedge clk); #1;
    check({req, " hit_fixed"}, 32'(hit_fixed), 32'(ef));
    check({req, " hit_alias"}, 32'(hit_alias), 32'(ea));
    check({req, " hit_any"},   32'(hit_any),   32'(ef | ea));
    check({req, " offset"},    32'(offset),    (ef | ea) ? 32'(a[11:0]) : 32'h0);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    mem_addr = 32'h0000_0000;
    repeat (3) @(posedge clk);
    #1;
    check("R1 hit_any", 32'(hit_any), 32'h0);
    check("R1 rdata", io_rdata, 32'h0);
    @(negedge clk); rst = 1'b0;
    io_read(PORT, "R1 reg");
    probe(32'h0000_0123, "R1 alias off");

    // R3: a write without arming
    io_write(PORT, 32'h8000_5000);
    io_read(PORT, "R3 unchanged");
    // R4 and R6: arm then load, reserved bits dropped
    io_write(PORT, KEY);
    io_write(PORT, 32'hC000_5FFF);
    io_read(PORT, "R4 R6 loaded");
    check("R6 layout", m_reg, 32'h8000_5000);
    probe(32'h0000_5123, "R7 alias hit");
    probe(32'h4000_5123, "R7 above 1G");
    probe(32'h0000_6123, "R7 next page");
    probe(32'hFFFE_F456, "R2 fixed");
    probe(32'hFFFE_E456, "R2 below fixed");
    // R5: foreign write between key and load
    io_write(PORT, KEY);
    io_write(16'h0CF8, 32'h1234_5678);
    io_write(PORT, 32'h8001_0000);
    io_read(PORT, "R5 foreign write");
    // R5: foreign read between
    io_write(PORT, KEY);
    io_read(16'h0CFC, "R9 other port");
    io_write(PORT, 32'h8002_0000);
    io_read(PORT, "R5 foreign read");
    // R5: non-key write does not arm
    io_write(PORT, 32'h8000_0001);
    io_write(PORT, 32'h8003_0000);
    io_read(PORT, "R5 nonkey");
    // R9: read of the base port keeps key armed
    io_write(PORT, KEY);
    io_read(PORT, "R9 read armed");
    io_write(PORT, 32'hBFFF_F000);
    io_read(PORT, "R9 load after read");
    probe(32'h3FFF_F00A, "R7 top page");
    probe(32'hFFFE_F00A, "R8 fixed");
    // key written twice: second loads the key value itself
    io_write(PORT, KEY);
    io_write(PORT, KEY);
    io_read(PORT, "R4 key as data");
    probe(32'h0000_0FFF, "R7 page zero");
    // disable alias
    io_write(PORT, KEY);
    io_write(PORT, 32'h0000_7000);
    probe(32'h0000_7001, "R7 disabled");

    for (int i = 0; i < 400; i++) begin
      int unsigned op;
      logic [31:0] a;
      op = $urandom_range(0, 9);
      case (op)
        0, 1: io_write(PORT, KEY);
        2: io_write(PORT, $urandom());
        3: io_write(PORT, $urandom() | 32'h8000_0000);
        4: io_write(16'($urandom()), $urandom());
        5: io_read(PORT, "R9 random read");
        6: io_read(16'($urandom()), "R9 random other");
        default: begin
          a = $urandom();
          case ($urandom_range(0, 3))
            0: a = {20'hFFFEF, a[11:0]};
            1: a = {2'b00, m_reg[29:12], a[11:0]};
            2: a = {2'b01, m_reg[29:12], a[11:0]};
            default: ;
          endcase
          probe(a, "R2 R7 R8 random");
        end
      endcase
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule